// File: doc/BRIEF.md
# Dual-Port Addressed Register Array

This block holds sixteen 8-bit registers that two independent ports can reach. The secondary port is an 8-bit multiplexed bus. A controller first sends an address on the bus with a select command, which latches a selection. Data moves on later cycles. A write command loads the selected register from the bus. When no command is active, the selected register drives the bus back.

The primary port is a 16-bit host or DMA port. It takes a 4-bit register address directly. In byte mode it reaches one register on the low lane. In word mode it reaches an aligned even/odd register pair across both lanes.

The pins are modelled as separate data-in, data-out and output-enable signals. All state changes on the rising clock edge, and reset is synchronous and active-high.

Top module: `dual_port_reg_bank`

## Requirements
- R1: After reset, every register reads 0x00 and no register is selected, so `sec_oe` stays low while the secondary port is enabled with no command.
- R2: While `sec_en_n` is low, `sec_sel` is high and `sec_wr` is low, a bus value in the range 0x30 to 0x3F selects the register whose index is the low four bits of that value.
- R3: A select command carrying a value outside 0x30 to 0x3F drops any existing selection. Later secondary writes then change no register, and `sec_oe` stays low.
- R4: A selection persists over any number of cycles without a select command, including cycles where `sec_en_n` is high.
- R5: While `sec_en_n` is low, `sec_wr` is high and `sec_sel` is low, the selected register loads `sec_din`. A write cycle with `sec_en_n` high, or with `sec_sel` and `sec_wr` both high, changes no register and no selection.
- R6: While `sec_en_n` is low, both commands are low and a register is selected, `sec_oe` is high and `sec_dout` equals that register.
- R7: A primary byte write (`pri_byte`=1, `pri_rd`=0, `pri_strobe`=1, port enabled) stores `pri_din[7:0]` into register `pri_addr`. Without the strobe, nothing is stored.
- R8: A primary word write (`pri_byte`=0) ignores `pri_addr[0]`. It stores `pri_din[15:8]` into the even register `{pri_addr[3:1],0}` and `pri_din[7:0]` into the odd register `{pri_addr[3:1],1}`.
- R9: With `pri_rd`=1 and the port enabled, `pri_oe` is high. A byte read gives `{8'h00, reg[pri_addr]}`. A word read gives `{even register, odd register}` of the addressed pair.
- R10: The primary port is enabled when `pri_pio_n` or `pri_dma_n` is low. With both high, it neither writes nor raises `pri_oe`. `pri_dma_n` has no effect on the secondary selection.
- R11: When both ports write the same register in the same cycle, the primary value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en_n | input | 1 | Secondary port enable, active low |
| sec_sel | input | 1 | Secondary select command |
| sec_wr | input | 1 | Secondary write command |
| sec_din | input | 8 | Secondary bus in (address or data) |
| sec_dout | output | 8 | Secondary bus out (selected register) |
| sec_oe | output | 1 | Secondary bus output enable |
| pri_pio_n | input | 1 | Primary addressed-mode enable, active low |
| pri_dma_n | input | 1 | Primary DMA enable, active low |
| pri_rd | input | 1 | Primary direction: 1 read, 0 write |
| pri_strobe | input | 1 | Primary write strobe |
| pri_byte | input | 1 | Primary width: 1 byte, 0 word |
| pri_addr | input | 4 | Primary register address |
| pri_din | input | 16 | Primary data in |
| pri_dout | output | 16 | Primary data out |
| pri_oe | output | 1 | Primary output enable |

## Verification
The bench attacks the sticky selection. It sends an out-of-range select and then a write; a design that keeps the old selection would corrupt that register. It holds the port disabled for cycles between select and read; a design that clears on disable would lose the read. It writes with both commands high and with the enable high; a design that decodes commands loosely would alter a register. On the primary side it writes a word at an odd address, where a design that does not force alignment would touch the wrong pair. It also writes the same register from both ports in one cycle to catch the wrong winner.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DW      = 8;
    localparam int NREGS   = 16;
    localparam int AW      = $clog2(NREGS);
    localparam logic [DW-1:0] SEL_BASE = 8'h30;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] idx_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } sel_t;

    typedef enum logic [1:0] {
        PRI_IDLE  = 2'd0,
        PRI_READ  = 2'd1,
        PRI_WRITE = 2'd2
    } pri_op_e;

    function automatic logic addr_hits(input byte_t v);
        return v[DW-1:AW] == SEL_BASE[DW-1:AW];
    endfunction

    function automatic idx_t pair_even(input idx_t a);
        return {a[AW-1:1], 1'b0};
    endfunction

    function automatic idx_t pair_odd(input idx_t a);
        return {a[AW-1:1], 1'b1};
    endfunction
endpackage

// File: rtl/regbank_select.sv
module regbank_select
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_cmd,
    input  byte_t bus_in,
    output sel_t  sel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_cmd) begin
            sel_q.valid <= addr_hits(bus_in);
            sel_q.idx   <= bus_in[AW-1:0];
        end
    end

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_cmd |=> $stable(sel_q));

    // R2
    sel_take_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_cmd && bus_in[DW-1:AW] == SEL_BASE[DW-1:AW])
        |=> (sel_q.valid && sel_q.idx == $past(bus_in[AW-1:0])));

    // R3
    sel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_cmd && bus_in[DW-1:AW] != SEL_BASE[DW-1:AW]) |=> !sel_q.valid);
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int N = NREGS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we_hi,
    input  idx_t  idx_hi,
    input  byte_t d_hi,
    input  logic  we_lo,
    input  idx_t  idx_lo,
    input  byte_t d_lo,
    input  logic  sec_we,
    input  idx_t  sec_idx,
    input  byte_t sec_d,
    output logic [N-1:0][DW-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (we_hi && idx_hi == AW'(g))
                q[g] <= d_hi;
            else if (we_lo && idx_lo == AW'(g))
                q[g] <= d_lo;
            else if (sec_we && sec_idx == AW'(g))
                q[g] <= sec_d;
        end
    end

    // R7
    pri_lo_store_chk: assert property (@(posedge clk) disable iff (rst)
        we_lo |=> q[$past(idx_lo)] == $past(d_lo));

    // R11
    pri_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_we && we_lo && sec_idx == idx_lo) |=> q[$past(sec_idx)] == $past(d_lo));

    // R5
    sec_store_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_we && !we_lo && !we_hi) |=> q[$past(sec_idx)] == $past(sec_d));
endmodule

// File: rtl/regbank_pri_port.sv
module regbank_pri_port
    import regbank_pkg::*;
#(
    parameter int N = NREGS
) (
    input  logic          pio_n,
    input  logic          dma_n,
    input  logic          rd,
    input  logic          strobe,
    input  logic          byte_mode,
    input  idx_t          addr,
    input  logic [2*DW-1:0] din,
    input  logic [N-1:0][DW-1:0] q,
    output logic          we_hi,
    output idx_t          idx_hi,
    output byte_t         d_hi,
    output logic          we_lo,
    output idx_t          idx_lo,
    output byte_t         d_lo,
    output logic [2*DW-1:0] dout,
    output logic          oe
);
    pri_op_e op;

    always_comb begin
        if (pio_n && dma_n) op = PRI_IDLE;
        else if (rd)        op = PRI_READ;
        else                op = PRI_WRITE;
    end

    always_comb begin
        we_lo  = (op == PRI_WRITE) && strobe;
        we_hi  = we_lo && !byte_mode;
        idx_hi = pair_even(addr);
        idx_lo = byte_mode ? addr : pair_odd(addr);
        d_hi   = din[2*DW-1:DW];
        d_lo   = din[DW-1:0];
        oe     = (op == PRI_READ);
        if (byte_mode) dout = {{DW{1'b0}}, q[addr]};
        else           dout = {q[pair_even(addr)], q[pair_odd(addr)]};
    end
endmodule

// File: rtl/dual_port_reg_bank.sv
module dual_port_reg_bank
    import regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sec_en_n,
    input  logic        sec_sel,
    input  logic        sec_wr,
    input  logic [7:0]  sec_din,
    output logic [7:0]  sec_dout,
    output logic        sec_oe,
    input  logic        pri_pio_n,
    input  logic        pri_dma_n,
    input  logic        pri_rd,
    input  logic        pri_strobe,
    input  logic        pri_byte,
    input  logic [3:0]  pri_addr,
    input  logic [15:0] pri_din,
    output logic [15:0] pri_dout,
    output logic        pri_oe
);
    sel_t  sel_q;
    logic  sel_cmd, wr_cmd;
    logic [NREGS-1:0][DW-1:0] q;
    logic  we_hi, we_lo;
    idx_t  idx_hi, idx_lo;
    byte_t d_hi, d_lo;

    assign sel_cmd  = !sec_en_n && sec_sel && !sec_wr;
    assign wr_cmd   = !sec_en_n && sec_wr && !sec_sel && sel_q.valid;
    assign sec_oe   = !sec_en_n && !sec_sel && !sec_wr && sel_q.valid;
    assign sec_dout = q[sel_q.idx];

    regbank_select u_sel (
        .clk(clk), .rst(rst), .sel_cmd(sel_cmd), .bus_in(sec_din), .sel_q(sel_q)
    );

    regbank_pri_port #(.N(NREGS)) u_pri (
        .pio_n(pri_pio_n), .dma_n(pri_dma_n), .rd(pri_rd), .strobe(pri_strobe),
        .byte_mode(pri_byte), .addr(pri_addr), .din(pri_din), .q(q),
        .we_hi(we_hi), .idx_hi(idx_hi), .d_hi(d_hi),
        .we_lo(we_lo), .idx_lo(idx_lo), .d_lo(d_lo),
        .dout(pri_dout), .oe(pri_oe)
    );

    regbank_store #(.N(NREGS)) u_store (
        .clk(clk), .rst(rst),
        .we_hi(we_hi), .idx_hi(idx_hi), .d_hi(d_hi),
        .we_lo(we_lo), .idx_lo(idx_lo), .d_lo(d_lo),
        .sec_we(wr_cmd), .sec_idx(sel_q.idx), .sec_d(sec_din), .q(q)
    );

    // R9
    byte_read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pri_oe && pri_byte) |-> pri_dout[15:8] == 8'h00);

    // R10
    pri_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pri_pio_n && pri_dma_n) |-> !pri_oe);
endmodule

// File: tb/dual_port_reg_bank_test.sv
module dual_port_reg_bank_test;
    logic clk = 1'b0;
    logic rst;
    logic sec_en_n, sec_sel, sec_wr;
    logic [7:0] sec_din, sec_dout;
    logic sec_oe;
    logic pri_pio_n, pri_dma_n, pri_rd, pri_strobe, pri_byte;
    logic [3:0] pri_addr;
    logic [15:0] pri_din, pri_dout;
    logic pri_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] rd_d;
    logic rd_oe;

    always #4 clk = ~clk;

    dual_port_reg_bank uut (.*);

    // {address, data}: primary byte writes read back over the secondary bus
    localparam logic [11:0] VEC [8] = '{
        {4'h0, 8'h11}, {4'h1, 8'hA5}, {4'h3, 8'h3C}, {4'h6, 8'hFF},
        {4'h9, 8'h80}, {4'hB, 8'h01}, {4'hE, 8'h7E}, {4'hF, 8'hC3}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        sec_en_n = 1; sec_sel = 0; sec_wr = 0; sec_din = 0;
        pri_pio_n = 1; pri_dma_n = 1; pri_rd = 0; pri_strobe = 0;
        pri_byte = 1; pri_addr = 0; pri_din = 0;
    endtask

    task automatic pwr(input logic bm, input logic [3:0] a, input logic [15:0] d);
        pri_pio_n = 0; pri_rd = 0; pri_strobe = 1; pri_byte = bm; pri_addr = a; pri_din = d;
        @(negedge clk); idle();
    endtask

    task automatic prd(input logic bm, input logic [3:0] a);
        pri_pio_n = 0; pri_rd = 1; pri_byte = bm; pri_addr = a;
        #1; rd_d = pri_dout; rd_oe = pri_oe; idle();
    endtask

    task automatic ssel(input logic [7:0] v);
        sec_en_n = 0; sec_sel = 1; sec_din = v;
        @(negedge clk); idle();
    endtask

    task automatic swr(input logic [7:0] v);
        sec_en_n = 0; sec_wr = 1; sec_din = v;
        @(negedge clk); idle();
    endtask

    task automatic srd();
        sec_en_n = 0;
        #1; rd_d = {8'h00, sec_dout}; rd_oe = sec_oe; idle();
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;

        // R1 reset state
        srd();  check("R1 no selection", {15'd0, rd_oe}, 16'd0);
        prd(0, 4'h4); check("R1 regs zero", rd_d, 16'h0000);

        // Table walk: R7 byte write, R2 select, R6 secondary read
        for (int i = 0; i < 8; i++) begin
            pwr(1, VEC[i][11:8], {8'hEE, VEC[i][7:0]});
            ssel({4'h3, VEC[i][11:8]});
            srd();
            check("R2/R6 oe", {15'd0, rd_oe}, 16'd1);
            check("R7 byte store", rd_d, {8'h00, VEC[i][7:0]});
        end

        // R9 byte and word reads
        prd(1, 4'h1); check("R9 byte read", rd_d, 16'h00A5);
        check("R9 oe", {15'd0, rd_oe}, 16'd1);
        prd(0, 4'h1); check("R9 word read", rd_d, 16'h11A5);

        // R8 word write at odd address aligns to pair 4/5
        pwr(0, 4'h5, 16'hBEEF);
        prd(1, 4'h4); check("R8 even gets high lane", rd_d, 16'h00BE);
        prd(1, 4'h5); check("R8 odd gets low lane", rd_d, 16'h00EF);
        prd(1, 4'h6); check("R8 neighbour untouched", rd_d, 16'h00FF);

        // R7 no strobe: no store
        pri_pio_n = 0; pri_rd = 0; pri_strobe = 0; pri_addr = 4'h2; pri_din = 16'h0055;
        @(negedge clk); idle();
        prd(1, 4'h2); check("R7 no strobe", rd_d, 16'h0000);

        // R5 secondary write, then ignored variants
        ssel(8'h32);
        swr(8'h5A);
        prd(1, 4'h2); check("R5 sec write", rd_d, 16'h005A);
        sec_en_n = 1; sec_wr = 1; sec_din = 8'h99; @(negedge clk); idle();
        prd(1, 4'h2); check("R5 disabled write ignored", rd_d, 16'h005A);
        sec_en_n = 0; sec_wr = 1; sec_sel = 1; sec_din = 8'h37; @(negedge clk); idle();
        prd(1, 4'h2); check("R5 both commands ignored", rd_d, 16'h005A);
        srd(); check("R5 selection kept", rd_d, 16'h005A);

        // R4 selection persists through disabled cycles
        repeat (5) @(negedge clk);
        srd(); check("R4 sticky", {7'd0, rd_oe, rd_d[7:0]}, {7'd0, 1'b1, 8'h5A});

        // R10 primary disabled: no write, no oe; DMA enable alone works
        pri_rd = 0; pri_strobe = 1; pri_addr = 4'h2; pri_din = 16'h0077; @(negedge clk); idle();
        prd(1, 4'h2); check("R10 disabled no write", rd_d, 16'h005A);
        pri_rd = 1; #1; check("R10 no oe", {15'd0, pri_oe}, 16'd0); idle();
        pri_dma_n = 0; pri_rd = 0; pri_strobe = 1; pri_byte = 1; pri_addr = 4'h7; pri_din = 16'h0042;
        @(negedge clk); idle();
        prd(1, 4'h7); check("R10 dma write", rd_d, 16'h0042);
        srd(); check("R10 sec selection unaffected", rd_d, 16'h005A);

        // R11 simultaneous write to same register
        ssel(8'h3A);
        sec_en_n = 0; sec_wr = 1; sec_din = 8'h55;
        pri_pio_n = 0; pri_rd = 0; pri_strobe = 1; pri_byte = 1; pri_addr = 4'hA; pri_din = 16'h00AA;
        @(negedge clk); idle();
        srd(); check("R11 primary wins", rd_d, 16'h00AA);

        // R3 out-of-range select drops selection, write ignored
        ssel(8'h40);
        srd(); check("R3 oe low", {15'd0, rd_oe}, 16'd0);
        swr(8'h13);
        prd(1, 4'hA); check("R3 write ignored reg A", rd_d, 16'h00AA);
        prd(1, 4'h0); check("R3 write ignored reg 0", rd_d, 16'h0011);

        // R1 reset again clears contents
        rst = 1; @(negedge clk); rst = 0;
        prd(0, 4'hA); check("R1 reset clears", rd_d, 16'h0000);

        finish_up();
    end
endmodule